// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block takes two asynchronous interrupt pins from outside the chip and turns each into a clean request for a downstream interrupt controller. Each channel has its own trigger setting. High level, low level, rising edge and falling edge all reduce to one of two output forms. The level settings produce an active-high level. The edge settings produce a one-cycle high pulse. Because of this, the downstream controller only ever needs to handle active-high levels and rising edges.

Software programs each channel through a small register file on a simple 32-bit read/write bus. The bus has a strobe, a write flag, a byte address, write data and read data. Read data is combinational and follows the address.

Each pin first passes through a two-flop synchronizer. It then goes through a per-channel state machine with five states:
- `CH_IDLE`: the channel is disabled.
- `CH_REARM`: a one-cycle settle state after any configuration write.
- `CH_LEVEL`: level following.
- `CH_WAIT`: waiting for an edge.
- `CH_FIRE`: the one-cycle pulse.

The transitions are as follows:
- Any configuration write moves the channel to `CH_REARM`, whatever state it is in. This takes priority over every other transition.
- From `CH_REARM` the channel goes to `CH_IDLE` if disabled, to `CH_LEVEL` if level sensitive, and to `CH_WAIT` otherwise.
- `CH_WAIT` goes to `CH_FIRE` when the polarity-corrected sample rises.
- `CH_FIRE` always returns to `CH_WAIT`.
- Any state with the enable clear and no write falls to `CH_IDLE`.

Top module: `ext_irq_cond`

## Requirements
- R1: Channel n (n = 0 or 1) has a configuration word at byte address 4 + 4*n. The enable is at bit 16, the level select at bit 9 and the polarity at bit 8. Reading the word returns the stored value of those three bits.
- R2: Address 0x0 always reads as zero. Writes to 0x0, or to any address that is not a channel word, change no channel state.
- R3: While bit 16 of a channel is clear, that channel's request output stays low. The output drops in the cycle right after the write that clears bit 16.
- R4: With bits 9 and 8 both set (high level), the output equals the pin value. The pin passes through two flops, so a pin change shows at the output two clock edges later.
- R5: With bit 9 set and bit 8 clear (low level), the output is high while the pin is low and low while the pin is high.
- R6: With bits 9 and 8 both clear (rising edge), each low-to-high pin transition gives exactly one high cycle on the output, three edges after the pin changes. A pin held high gives no more pulses.
- R7: With bit 9 clear and bit 8 set (falling edge), each high-to-low pin transition gives one high cycle. Rising transitions give nothing.
- R8: All configuration bits other than 16, 9 and 8 read as zero, and writing them has no effect.
- R9: Any write to a channel word clears that channel's edge history, and the output stays low in the cycle after the write. A change of polarity alone never produces a pulse.
- R10: After reset, all configuration words read zero and both outputs are low.
- R11: The two channels work independently, each with its own setting and pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| irq_pin | input | 2 | Raw external interrupt pins, one per channel |
| irq_req | output | 2 | Normalized requests to the downstream controller |

## Verification
A channel stuck in the wrong state appears at its output within one to three cycles of the next pin transition. A stuck `CH_LEVEL` state shows a level where a single pulse is expected. A missed `CH_FIRE` state leaves an edge with no pulse. An edge history that is not cleared shows as a stray pulse in the two cycles after a polarity-only rewrite, while the pin is held still. Register decode faults show up immediately as wrong readback data, or as a neighbouring channel reacting to the wrong pin.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int CFG_EN_BIT  = 16;
    localparam int CFG_LVL_BIT = 9;
    localparam int CFG_POL_BIT = 8;

    typedef struct packed {
        logic en;
        logic lvl;
        logic pol;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_REARM,
        CH_LEVEL,
        CH_WAIT,
        CH_FIRE
    } chan_state_t;

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];

    // R4
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout == $past(chain_q[STAGES-2]));

endmodule

// File: rtl/eic_regfile.sv
module eic_regfile
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output chan_cfg_t         cfg   [NUM_CH],
    output logic [NUM_CH-1:0] cfg_chg
);
    localparam logic [DATA_W-1:0] CFG_MASK =
        (DATA_W'(1) << CFG_EN_BIT) | (DATA_W'(1) << CFG_LVL_BIT) | (DATA_W'(1) << CFG_POL_BIT);

    function automatic logic [ADDR_W-1:0] ch_addr(input int n);
        return ADDR_W'(4 + 4 * n);
    endfunction

    logic [NUM_CH-1:0] hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign hit[g] = (bus_addr == ch_addr(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg[g]     <= '0;
                cfg_chg[g] <= 1'b0;
            end else begin
                cfg_chg[g] <= bus_en && bus_we && hit[g];
                if (bus_en && bus_we && hit[g]) begin
                    cfg[g].en  <= bus_wdata[CFG_EN_BIT];
                    cfg[g].lvl <= bus_wdata[CFG_LVL_BIT];
                    cfg[g].pol <= bus_wdata[CFG_POL_BIT];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (hit[n]) begin
                bus_rdata[CFG_EN_BIT]  = cfg[n].en;
                bus_rdata[CFG_LVL_BIT] = cfg[n].lvl;
                bus_rdata[CFG_POL_BIT] = cfg[n].pol;
            end
        end
    end

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~CFG_MASK) == '0);

    // R2
    global_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata == '0));

endmodule

// File: rtl/eic_chan.sv
module eic_chan
    import ext_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_sync,
    input  chan_cfg_t cfg,
    input  logic      cfg_chg,
    output logic      req
);
    chan_state_t state_q, state_d;
    logic        norm;
    logic        prev_q;

    // Fold the four trigger types into active-high level / rising edge.
    assign norm = pin_sync ^ (cfg.lvl ? ~cfg.pol : cfg.pol);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= norm;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  state_d = CH_IDLE;
            CH_REARM: state_d = !cfg.en ? CH_IDLE : (cfg.lvl ? CH_LEVEL : CH_WAIT);
            CH_LEVEL: state_d = CH_LEVEL;
            CH_WAIT:  state_d = (norm && !prev_q) ? CH_FIRE : CH_WAIT;
            CH_FIRE:  state_d = CH_WAIT;
            default:  state_d = CH_IDLE;
        endcase
        if (cfg_chg)      state_d = CH_REARM;
        else if (!cfg.en) state_d = CH_IDLE;
    end

    always_comb begin
        req = 1'b0;
        unique case (state_q)
            CH_LEVEL: req = cfg.en && cfg.lvl && norm;
            CH_FIRE:  req = cfg.en && !cfg.lvl;
            default:  req = 1'b0;
        endcase
    end

    // R9
    chg_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (state_q == CH_REARM));

    // R9
    rearm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_REARM) |-> !req);

    // R6
    fire_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_FIRE) |=> (state_q != CH_FIRE));

    // R3
    idle_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE) |-> (!cfg.en || cfg_chg));

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
    import ext_irq_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] irq_pin,
    output logic [NUM_CH-1:0] irq_req
);
    chan_cfg_t         cfg [NUM_CH];
    logic [NUM_CH-1:0] cfg_chg;
    logic [NUM_CH-1:0] pin_sync;

    eic_regfile #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cfg      (cfg),
        .cfg_chg  (cfg_chg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        eic_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (irq_pin[g]),
            .dout (pin_sync[g])
        );

        eic_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_sync(pin_sync[g]),
            .cfg     (cfg[g]),
            .cfg_chg (cfg_chg[g]),
            .req     (irq_req[g])
        );
    end

endmodule

// File: tb/ext_irq_cond_test.sv
module ext_irq_cond_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_pin = '0;
    logic [1:0]  irq_req;

    int runs = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_rd;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #4 clk = ~clk;

    ext_irq_cond uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_pin(irq_pin), .irq_req(irq_req)
    );

    // Monitor: compares queued expectations shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            act = it.is_rd ? bus_rdata : {30'd0, irq_req};
            runs++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [1:0] e, input string tag);
        item_t it;
        it.is_rd = 1'b0; it.exp = {30'd0, e}; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        it.is_rd = 1'b1; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        tick(1);
        bus_en = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            runs++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_out(2'b00, "R10 outputs low in reset");
        tick(1);
        rst_n = 1'b1;
        tick(1);
        bus_read(8'h04, 32'h0, "R10 ch0 word reset");
        bus_read(8'h08, 32'h0, "R10 ch1 word reset");

        // R2: global and unmapped addresses
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, 32'h0, "R2 global reads zero");
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'h0, "R2 ch0 untouched");
        bus_read(8'h08, 32'h0, "R2 ch1 untouched");

        // R1 / R8: readback and reserved bits
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'h0001_0300, "R8 only bits 16,9,8 kept");
        bus_write(8'h04, 32'h0);
        bus_read(8'h04, 32'h0, "R1 ch0 zero write");
        bus_write(8'h08, 32'h0001_0100);
        bus_read(8'h08, 32'h0001_0100, "R1 ch1 readback");
        bus_write(8'h08, 32'h0);

        // R3: level-high config without enable
        bus_write(8'h04, 32'h0000_0300);
        irq_pin[0] = 1'b1;
        tick(4);
        expect_out(2'b00, "R3 disabled channel silent");
        irq_pin[0] = 1'b0;

        // R4: level high
        bus_write(8'h04, 32'h0001_0300);
        tick(3);
        irq_pin[0] = 1'b1;
        tick(1);
        expect_out(2'b00, "R4 one edge not yet visible");
        tick(1);
        expect_out(2'b01, "R4 level high follows pin");
        irq_pin[0] = 1'b0;
        tick(2);
        expect_out(2'b00, "R4 level high drops");
        irq_pin[0] = 1'b1;
        tick(3);
        bus_write(8'h04, 32'h0000_0300);
        expect_out(2'b00, "R3 drop right after disable write");
        irq_pin[0] = 1'b0;

        // R5: level low
        bus_write(8'h04, 32'h0001_0200);
        tick(3);
        expect_out(2'b01, "R5 low pin asserts");
        irq_pin[0] = 1'b1;
        tick(2);
        expect_out(2'b00, "R5 high pin deasserts");
        irq_pin[0] = 1'b0;

        // R6: rising edge
        bus_write(8'h04, 32'h0001_0000);
        tick(3);
        expect_out(2'b00, "R6 idle before edge");
        irq_pin[0] = 1'b1;
        tick(2);
        expect_out(2'b00, "R6 no early pulse");
        tick(1);
        expect_out(2'b01, "R6 rising pulse");
        tick(1);
        expect_out(2'b00, "R6 pulse one cycle");
        tick(4);
        expect_out(2'b00, "R6 held high no repeat");
        irq_pin[0] = 1'b0;
        tick(4);
        expect_out(2'b00, "R6 falling ignored");

        // R7: falling edge on ch1
        bus_write(8'h08, 32'h0001_0100);
        tick(3);
        irq_pin[1] = 1'b1;
        tick(3);
        expect_out(2'b00, "R7 rising ignored");
        tick(2);
        irq_pin[1] = 1'b0;
        tick(3);
        expect_out(2'b10, "R7 falling pulse");
        tick(1);
        expect_out(2'b00, "R7 pulse one cycle");

        // R9: ch0 rising with pin low, switch to falling: no spurious pulse
        bus_write(8'h04, 32'h0001_0100);
        expect_out(2'b00, "R9 quiet after write c1");
        for (int i = 0; i < 5; i++) begin
            tick(1);
            expect_out(2'b00, "R9 no pulse on reconfig");
        end
        irq_pin[0] = 1'b1;
        tick(4);
        irq_pin[0] = 1'b0;
        tick(3);
        expect_out(2'b01, "R9 real falling edge still pulses");

        // R11: independent level channels
        bus_write(8'h04, 32'h0001_0300);
        bus_write(8'h08, 32'h0001_0200);
        irq_pin = 2'b11;
        tick(4);
        expect_out(2'b01, "R11 ch0 high, ch1 low-level idle");
        irq_pin = 2'b01;
        tick(2);
        expect_out(2'b11, "R11 both asserted");
        irq_pin = 2'b00;
        tick(2);
        expect_out(2'b10, "R11 only ch1 asserted");

        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule